// File: doc/BRIEF.md
# Path Overhead Serial Access Channel

This block carries path overhead bytes between the framing datapath and an external device over a slow serial link. The link has a bit clock, a frame sync pulse and one data line in each direction, and the block sources the clock and the sync for both directions. Every frame carries exactly eight bytes. Each byte goes out most significant bit first and is followed by one parity bit. A run of idle bit slots then pads the frame out to its full period.

In the drop direction, the block takes the overhead bytes captured from each received frame into a capture buffer. At each frame boundary it copies them into a second buffer, and shifts that second buffer out while the next frame's bytes are being captured. In the add direction, the block deserialises the incoming stream and checks the parity of every byte. A byte that arrives with good parity becomes that slot's insertion value for the overhead generator. A byte with bad parity is discarded and raises a sticky error flag. A slot that is not enabled for insertion presents a stuff value instead, all ones or all zeros as configured. The slot that carries the path BIP byte is never enabled, because that byte is always computed inside the generator. Parity is even or odd as selected, and the selection applies to both directions.

Top module: `poh_serial_chan`

## Requirements
- R1: While reset is asserted and directly after it, the outputs are as follows. sync_o, drop_data_o and par_err_o are 0. Every stored insertion byte is 0, so with ins_en_i all zeros and stuff_ones_i at 0, ins_bytes_o reads all zeros.
- R2: A frame is NBYTES×(BW+1)+GAP bit slots long, with defaults 8, 8 and 8, giving 80 slots. Each slot lasts DIV clock cycles (default 4).
  - Byte k occupies slots 9k to 9k+8: its data bits come first, MSB first, and its parity bit is in slot 9k+8.
  - drop_data_o is 0 in the GAP idle slots.
  - Byte k is carried on bits [8k+7:8k] of the flat byte ports.
- R3: sync_o is 1 for exactly the first bit slot of byte 0 and 0 at all other times. That slot is a data slot carrying bit 7 of byte 0.
- R4: The parity bit equals the XOR of the byte's bits, inverted when par_odd_i is 1. With par_odd_i at 0, a byte plus its parity bit holds an even number of ones. With par_odd_i at 1, it holds an odd number.
- R5: The bytes shifted out in a frame are those stored by the last cap_stb_i accepted before that frame began.
  - A strobe during the frame does not alter the frame being shifted out.
  - A strobe in the final clock cycle before the frame's first slot belongs to the following frame.
- R6: ser_clk_o is 0 for the first DIV/2 cycles of every slot and 1 for the remainder, continuously.
- R7: add_data_i is sampled in the last clock cycle of each data or parity slot. A byte received with correct parity is presented as the stored value of its slot from then on.
- R8: When a byte fails its parity check, the following happens:
  - its stored value is kept unchanged;
  - par_err_o is set and stays set until err_clr_i is raised;
  - if a parity error and err_clr_i occur in the same cycle, the flag is set.
- R9: For every slot k, ins_en_o[k] is ins_en_i[k] masked as R10 describes. When ins_en_o[k] is 0, the slot's byte on ins_bytes_o is all ones if stuff_ones_i is 1 and all zeros otherwise.
- R10: Slot B3_SLOT (default 1) always shows ins_en_o low and the stuff value, whatever ins_en_i is.
- R11: add_data_i has no effect in the GAP idle slots or in any cycle of a slot other than its last.

Timing states of the slot sequencer:
- TS_GAP: idle padding slots. Reset enters it with its counter at the final idle slot.
- TS_DATA: data bit slots.
- TS_PAR: the parity slot of each byte.

Transitions, each taken at the last cycle of a slot:
- TS_DATA→TS_DATA: next bit.
- TS_DATA→TS_PAR: after bit BW-1.
- TS_PAR→TS_DATA: next byte.
- TS_PAR→TS_GAP: after the last byte.
- TS_GAP→TS_GAP: next idle slot.
- TS_GAP→TS_DATA: after the last idle slot. This is the frame load, when the capture buffer is copied to the shift-out buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| par_odd_i | input | 1 | Parity sense for both directions: 1 selects odd parity |
| cap_stb_i | input | 1 | Strobe that stores cap_bytes_i in the capture buffer |
| cap_bytes_i | input | NBYTES*BW | Captured overhead bytes from the received frame |
| ser_clk_o | output | 1 | Serial bit clock sourced by the block |
| sync_o | output | 1 | Frame sync, high in the first bit slot of byte 0 |
| drop_data_o | output | 1 | Serial drop stream |
| add_data_i | input | 1 | Serial add stream from the external device |
| ins_en_i | input | NBYTES | Per-slot insertion enable |
| stuff_ones_i | input | 1 | Stuff value selector: 1 gives all ones, 0 gives all zeros |
| err_clr_i | input | 1 | Clears the sticky parity error flag |
| ins_bytes_o | output | NBYTES*BW | Insertion byte values for the overhead generator |
| ins_en_o | output | NBYTES | Effective insertion enable for each slot |
| par_err_o | output | 1 | Sticky add-side parity error flag |

## Verification
Two pairs of functions can act in the same clock cycle, and the bench provokes both.

The first pair is a capture strobe and the frame load. The bench raises cap_stb_i in the last cycle of the last idle slot. It then judges at the port that the frame which follows still shifts out the older capture, and that the strobed bytes only appear one frame later.

The second pair is a parity failure and an error clear. The bench sends a byte with deliberately wrong parity and raises err_clr_i in that byte's parity-sampling cycle. It then expects par_err_o to read 1 afterwards, and expects the slot's stored byte to keep its previous value.

// File: rtl/poh_chan_pkg.sv
package poh_chan_pkg;

    typedef enum logic [1:0] {
        TS_GAP  = 2'd0,
        TS_DATA = 2'd1,
        TS_PAR  = 2'd2
    } slot_state_e;

endpackage

// File: rtl/poh_slot_timer.sv
module poh_slot_timer
    import poh_chan_pkg::*;
#(
    parameter int NBYTES = 8,
    parameter int BW     = 8,
    parameter int DIV    = 4,
    parameter int GAP    = 8,
    localparam int DIVW  = $clog2(DIV),
    localparam int BITW  = $clog2(BW),
    localparam int BYTW  = $clog2(NBYTES),
    localparam int GAPW  = $clog2(GAP)
) (
    input  logic            clk,
    input  logic            rst,
    output slot_state_e     state_o,
    output logic [BITW-1:0] bit_o,
    output logic [BYTW-1:0] byte_o,
    output logic            tick_last_o,
    output logic            frame_load_o,
    output logic            sync_o,
    output logic            ser_clk_o
);

    localparam logic [DIVW-1:0] DIV_LAST  = DIVW'(DIV - 1);
    localparam logic [DIVW-1:0] DIV_HALF  = DIVW'(DIV / 2);
    localparam logic [BITW-1:0] BIT_LAST  = BITW'(BW - 1);
    localparam logic [BYTW-1:0] BYTE_LAST = BYTW'(NBYTES - 1);
    localparam logic [GAPW-1:0] GAP_LAST  = GAPW'(GAP - 1);

    slot_state_e     state_q, state_d;
    logic [DIVW-1:0] div_q, div_d;
    logic [BITW-1:0] bit_q, bit_d;
    logic [BYTW-1:0] byte_q, byte_d;
    logic [GAPW-1:0] gap_q, gap_d;
    logic            tick_last;

    assign tick_last = (div_q == DIV_LAST);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TS_GAP;
            div_q   <= '0;
            bit_q   <= '0;
            byte_q  <= '0;
            gap_q   <= GAP_LAST;
        end else begin
            state_q <= state_d;
            div_q   <= div_d;
            bit_q   <= bit_d;
            byte_q  <= byte_d;
            gap_q   <= gap_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        byte_d  = byte_q;
        gap_d   = gap_q;
        div_d   = tick_last ? '0 : div_q + 1'b1;
        if (tick_last) begin
            unique case (state_q)
                TS_DATA: begin
                    if (bit_q == BIT_LAST) begin
                        state_d = TS_PAR;
                        bit_d   = '0;
                    end else begin
                        bit_d = bit_q + 1'b1;
                    end
                end
                TS_PAR: begin
                    if (byte_q == BYTE_LAST) begin
                        state_d = TS_GAP;
                        byte_d  = '0;
                        gap_d   = '0;
                    end else begin
                        state_d = TS_DATA;
                        byte_d  = byte_q + 1'b1;
                    end
                end
                TS_GAP: begin
                    if (gap_q == GAP_LAST) begin
                        state_d = TS_DATA;
                        gap_d   = '0;
                        bit_d   = '0;
                        byte_d  = '0;
                    end else begin
                        gap_d = gap_q + 1'b1;
                    end
                end
                default: begin
                    state_d = TS_GAP;
                    gap_d   = GAP_LAST;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        state_o      = state_q;
        bit_o        = bit_q;
        byte_o       = byte_q;
        tick_last_o  = tick_last;
        frame_load_o = tick_last && (state_q == TS_GAP) && (gap_q == GAP_LAST);
        sync_o       = (state_q == TS_DATA) && (byte_q == '0) && (bit_q == '0);
        ser_clk_o    = (div_q >= DIV_HALF);
    end

endmodule

// File: rtl/poh_drop_ser.sv
module poh_drop_ser
    import poh_chan_pkg::*;
#(
    parameter int NBYTES = 8,
    parameter int BW     = 8,
    localparam int BITW  = $clog2(BW),
    localparam int BYTW  = $clog2(NBYTES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  slot_state_e          state_i,
    input  logic [BITW-1:0]      bit_i,
    input  logic [BYTW-1:0]      byte_i,
    input  logic                 frame_load_i,
    input  logic                 par_odd_i,
    input  logic                 cap_stb_i,
    input  logic [NBYTES*BW-1:0] cap_bytes_i,
    output logic                 drop_o
);

    localparam logic [BITW-1:0] MSB_IDX = BITW'(BW - 1);

    logic [BW-1:0] cap_q [NBYTES];
    logic [BW-1:0] out_q [NBYTES];
    logic [BW-1:0] cur_byte;

    for (genvar k = 0; k < NBYTES; k++) begin : g_buf
        always_ff @(posedge clk) begin
            if (rst) begin
                cap_q[k] <= '0;
                out_q[k] <= '0;
            end else begin
                if (cap_stb_i) begin
                    cap_q[k] <= cap_bytes_i[k*BW +: BW];
                end
                if (frame_load_i) begin
                    out_q[k] <= cap_q[k];
                end
            end
        end
    end

    assign cur_byte = out_q[byte_i];

    always_comb begin
        unique case (state_i)
            TS_DATA: drop_o = cur_byte[MSB_IDX - bit_i];
            TS_PAR:  drop_o = (^cur_byte) ^ par_odd_i;
            default: drop_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/poh_add_deser.sv
module poh_add_deser
    import poh_chan_pkg::*;
#(
    parameter int NBYTES = 8,
    parameter int BW     = 8,
    localparam int BYTW  = $clog2(NBYTES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  slot_state_e          state_i,
    input  logic [BYTW-1:0]      byte_i,
    input  logic                 tick_last_i,
    input  logic                 par_odd_i,
    input  logic                 din_i,
    input  logic                 err_clr_i,
    output logic [NBYTES*BW-1:0] held_o,
    output logic                 par_bad_o,
    output logic                 err_o
);

    logic [BW-1:0] sh_q;
    logic [BW-1:0] held_q [NBYTES];
    logic          err_q;
    logic          par_samp;
    logic          par_ok;

    assign par_samp  = tick_last_i && (state_i == TS_PAR);
    assign par_ok    = ((^sh_q) ^ din_i) == par_odd_i;
    assign par_bad_o = par_samp && !par_ok;
    assign err_o     = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (tick_last_i && (state_i == TS_DATA)) begin
            sh_q <= {sh_q[BW-2:0], din_i};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (par_bad_o) begin
            err_q <= 1'b1;
        end else if (err_clr_i) begin
            err_q <= 1'b0;
        end
    end

    for (genvar k = 0; k < NBYTES; k++) begin : g_held
        always_ff @(posedge clk) begin
            if (rst) begin
                held_q[k] <= '0;
            end else if (par_samp && par_ok && (byte_i == BYTW'(k))) begin
                held_q[k] <= sh_q;
            end
        end
        assign held_o[k*BW +: BW] = held_q[k];
    end

endmodule

// File: rtl/poh_ins_mux.sv
module poh_ins_mux #(
    parameter int NBYTES  = 8,
    parameter int BW      = 8,
    parameter int B3_SLOT = 1
) (
    input  logic [NBYTES*BW-1:0] held_i,
    input  logic [NBYTES-1:0]    ins_en_i,
    input  logic                 stuff_ones_i,
    output logic [NBYTES*BW-1:0] ins_bytes_o,
    output logic [NBYTES-1:0]    ins_en_o
);

    for (genvar k = 0; k < NBYTES; k++) begin : g_slot
        if (k == B3_SLOT) begin : g_b3
            assign ins_en_o[k] = 1'b0;
        end else begin : g_norm
            assign ins_en_o[k] = ins_en_i[k];
        end
        assign ins_bytes_o[k*BW +: BW] = ins_en_o[k] ? held_i[k*BW +: BW]
                                                     : {BW{stuff_ones_i}};
    end

endmodule

// File: rtl/poh_serial_chan.sv
module poh_serial_chan
    import poh_chan_pkg::*;
#(
    parameter int NBYTES  = 8,
    parameter int BW      = 8,
    parameter int DIV     = 4,
    parameter int GAP     = 8,
    parameter int B3_SLOT = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 par_odd_i,
    input  logic                 cap_stb_i,
    input  logic [NBYTES*BW-1:0] cap_bytes_i,
    output logic                 ser_clk_o,
    output logic                 sync_o,
    output logic                 drop_data_o,
    input  logic                 add_data_i,
    input  logic [NBYTES-1:0]    ins_en_i,
    input  logic                 stuff_ones_i,
    input  logic                 err_clr_i,
    output logic [NBYTES*BW-1:0] ins_bytes_o,
    output logic [NBYTES-1:0]    ins_en_o,
    output logic                 par_err_o
);

    localparam int BITW = $clog2(BW);
    localparam int BYTW = $clog2(NBYTES);

    slot_state_e          tm_state;
    logic [BITW-1:0]      tm_bit;
    logic [BYTW-1:0]      tm_byte;
    logic                 tm_tick_last;
    logic                 tm_frame_load;
    logic [NBYTES*BW-1:0] add_held;
    logic                 add_par_bad;

    poh_slot_timer #(
        .NBYTES (NBYTES),
        .BW     (BW),
        .DIV    (DIV),
        .GAP    (GAP)
    ) u_timer (
        .clk          (clk),
        .rst          (rst),
        .state_o      (tm_state),
        .bit_o        (tm_bit),
        .byte_o       (tm_byte),
        .tick_last_o  (tm_tick_last),
        .frame_load_o (tm_frame_load),
        .sync_o       (sync_o),
        .ser_clk_o    (ser_clk_o)
    );

    poh_drop_ser #(
        .NBYTES (NBYTES),
        .BW     (BW)
    ) u_drop (
        .clk          (clk),
        .rst          (rst),
        .state_i      (tm_state),
        .bit_i        (tm_bit),
        .byte_i       (tm_byte),
        .frame_load_i (tm_frame_load),
        .par_odd_i    (par_odd_i),
        .cap_stb_i    (cap_stb_i),
        .cap_bytes_i  (cap_bytes_i),
        .drop_o       (drop_data_o)
    );

    poh_add_deser #(
        .NBYTES (NBYTES),
        .BW     (BW)
    ) u_add (
        .clk         (clk),
        .rst         (rst),
        .state_i     (tm_state),
        .byte_i      (tm_byte),
        .tick_last_i (tm_tick_last),
        .par_odd_i   (par_odd_i),
        .din_i       (add_data_i),
        .err_clr_i   (err_clr_i),
        .held_o      (add_held),
        .par_bad_o   (add_par_bad),
        .err_o       (par_err_o)
    );

    poh_ins_mux #(
        .NBYTES  (NBYTES),
        .BW      (BW),
        .B3_SLOT (B3_SLOT)
    ) u_mux (
        .held_i       (add_held),
        .ins_en_i     (ins_en_i),
        .stuff_ones_i (stuff_ones_i),
        .ins_bytes_o  (ins_bytes_o),
        .ins_en_o     (ins_en_o)
    );

endmodule

// File: rtl/poh_chan_chk.sv
module poh_chan_chk
    import poh_chan_pkg::*;
#(
    parameter int NBYTES  = 8,
    parameter int BW      = 8,
    parameter int B3_SLOT = 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 sync_o,
    input logic                 ser_clk_o,
    input logic                 drop_data_o,
    input logic                 err_clr_i,
    input logic                 par_err_o,
    input logic                 add_par_bad,
    input slot_state_e          tm_state,
    input logic [NBYTES-1:0]    ins_en_i,
    input logic [NBYTES-1:0]    ins_en_o,
    input logic [NBYTES*BW-1:0] ins_bytes_o,
    input logic                 stuff_ones_i
);

    // R3
    sync_slot_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_o) |-> !ser_clk_o);

    // R2
    gap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (tm_state == TS_GAP) |-> !drop_data_o);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (par_err_o && !err_clr_i) |=> par_err_o);

    // R8
    err_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        add_par_bad |=> par_err_o);

    // R10
    b3_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        ins_en_i[B3_SLOT] |-> (!ins_en_o[B3_SLOT] &&
            ins_bytes_o[B3_SLOT*BW +: BW] == {BW{stuff_ones_i}}));

    for (genvar k = 0; k < NBYTES; k++) begin : g_stuff
        // R9
        stuff_value_chk: assert property (@(posedge clk) disable iff (rst)
            !ins_en_o[k] |-> (ins_bytes_o[k*BW +: BW] == {BW{stuff_ones_i}}));
    end

endmodule

bind poh_serial_chan poh_chan_chk #(
    .NBYTES  (NBYTES),
    .BW      (BW),
    .B3_SLOT (B3_SLOT)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sync_o       (sync_o),
    .ser_clk_o    (ser_clk_o),
    .drop_data_o  (drop_data_o),
    .err_clr_i    (err_clr_i),
    .par_err_o    (par_err_o),
    .add_par_bad  (add_par_bad),
    .tm_state     (tm_state),
    .ins_en_i     (ins_en_i),
    .ins_en_o     (ins_en_o),
    .ins_bytes_o  (ins_bytes_o),
    .stuff_ones_i (stuff_ones_i)
);

// File: tb/poh_serial_chan_tb.sv
module poh_serial_chan_tb;

    localparam int NB    = 8;
    localparam int SLOTS = 80;

    logic          clk = 1'b0;
    logic          rst;
    logic          par_odd_i;
    logic          cap_stb_i;
    logic [63:0]   cap_bytes_i;
    logic          ser_clk_o;
    logic          sync_o;
    logic          drop_data_o;
    logic          add_data_i;
    logic [7:0]    ins_en_i;
    logic          stuff_ones_i;
    logic          err_clr_i;
    logic [63:0]   ins_bytes_o;
    logic [7:0]    ins_en_o;
    logic          par_err_o;

    int            n_chk  = 0;
    int            n_fail = 0;
    logic          done   = 1'b0;
    logic [7:0]    exp_held [NB];

    always #4 clk = ~clk;

    poh_serial_chan u_dut (
        .clk          (clk),
        .rst          (rst),
        .par_odd_i    (par_odd_i),
        .cap_stb_i    (cap_stb_i),
        .cap_bytes_i  (cap_bytes_i),
        .ser_clk_o    (ser_clk_o),
        .sync_o       (sync_o),
        .drop_data_o  (drop_data_o),
        .add_data_i   (add_data_i),
        .ins_en_i     (ins_en_i),
        .stuff_ones_i (stuff_ones_i),
        .err_clr_i    (err_clr_i),
        .ins_bytes_o  (ins_bytes_o),
        .ins_en_o     (ins_en_o),
        .par_err_o    (par_err_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_ins(input logic [7:0] en, input logic ones);
        logic [63:0] v;
        for (int k = 0; k < NB; k++) begin
            v[8*k +: 8] = (en[k] && k != 1) ? exp_held[k] : {8{ones}};
        end
        return v;
    endfunction

    // one full frame from the negedge in which sync has just risen
    task automatic run_frame(input logic [63:0] addv, input logic [7:0] badm,
                             input int mid_slot, input logic [63:0] mid_val,
                             input logic end_stb, input logic [63:0] end_val,
                             input int clr_slot,
                             output logic [63:0] dv, output logic [7:0] dp,
                             output int e_sync, output int e_clk, output int e_gap);
        e_sync = 0; e_clk = 0; e_gap = 0; dv = '0; dp = '0;
        for (int s = 0; s < SLOTS; s++) begin
            for (int d = 0; d < 4; d++) begin
                int  b;
                int  pos;
                logic bitv;
                b   = s / 9;
                pos = s % 9;
                if (s < 72) begin
                    if (pos < 8) bitv = addv[8*b + 7 - pos];
                    else         bitv = par_odd_i ^ (^addv[8*b +: 8]) ^ badm[b];
                    add_data_i = (d == 3) ? bitv : ~bitv; // R11 junk off the sample cycle
                end else begin
                    add_data_i = 1'b1;                    // R11 junk in gap
                end
                cap_stb_i = 1'b0;
                if (s == mid_slot && d == 0) begin
                    cap_stb_i = 1'b1; cap_bytes_i = mid_val;
                end
                if (end_stb && s == SLOTS - 1 && d == 3) begin
                    cap_stb_i = 1'b1; cap_bytes_i = end_val;
                end
                err_clr_i = (s == clr_slot && d == 3);
                if (sync_o !== (s == 0)) e_sync++;
                if (ser_clk_o !== (d >= 2)) e_clk++;
                if (d == 1) begin
                    if (s < 72) begin
                        if (pos < 8) dv[8*b + 7 - pos] = drop_data_o;
                        else         dp[b] = drop_data_o;
                    end else if (drop_data_o !== 1'b0) begin
                        e_gap++;
                    end
                end
                @(negedge clk);
            end
        end
        cap_stb_i = 1'b0; err_clr_i = 1'b0; add_data_i = 1'b0;
        for (int k = 0; k < NB; k++) begin
            if (!badm[k]) exp_held[k] = addv[8*k +: 8];
        end
    endtask

    function automatic logic [7:0] exp_par(input logic [63:0] v, input logic odd);
        logic [7:0] p;
        for (int k = 0; k < NB; k++) p[k] = (^v[8*k +: 8]) ^ odd;
        return p;
    endfunction

    task automatic t_reset;
        rst = 1'b1; par_odd_i = 0; cap_stb_i = 0; cap_bytes_i = '0; add_data_i = 0;
        ins_en_i = '0; stuff_ones_i = 0; err_clr_i = 0;
        for (int k = 0; k < NB; k++) exp_held[k] = '0;
        repeat (3) @(negedge clk);
        chk("R1 sync in reset", {63'b0, sync_o}, 64'd0);
        chk("R1 drop in reset", {63'b0, drop_data_o}, 64'd0);
        chk("R1 err in reset", {63'b0, par_err_o}, 64'd0);
        chk("R1 ins bytes in reset", ins_bytes_o, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 sync after reset", {63'b0, sync_o}, 64'd0);
        while (sync_o !== 1'b1) @(negedge clk);
    endtask

    task automatic t_first_frame;
        logic [63:0] dv; logic [7:0] dp; int es, ec, eg;
        ins_en_i = 8'hFF;
        run_frame(64'h0123_4567_89AB_CDEF, 8'h00, 20, 64'hA1A2_A3A4_A5A6_A7A8,
                  1'b0, '0, -1, dv, dp, es, ec, eg);
        chk("R5 first frame keeps reset content", dv, 64'd0);
        chk("R3 sync position", es, 0);
        chk("R6 serial clock shape", ec, 0);
        chk("R2 gap slots quiet", eg, 0);
        chk("R7 received bytes presented", ins_bytes_o, exp_ins(8'hFF, 1'b0));
        chk("R10 enable flag mask", {56'b0, ins_en_o}, 64'h0000_0000_0000_00FD);
        chk("R11 junk ignored, err clear", {63'b0, par_err_o}, 64'd0);
    endtask

    task automatic t_collision;
        logic [63:0] dv; logic [7:0] dp; int es, ec, eg;
        run_frame(64'hF0E1_D2C3_B4A5_9687, 8'h00, 40, 64'hC0C1_C2C3_C4C5_C6C7,
                  1'b1, 64'hB0B1_B2B3_B4B5_B6B7, -1, dv, dp, es, ec, eg);
        chk("R5 mid-frame strobe shown next frame", dv, 64'hA1A2_A3A4_A5A6_A7A8);
        chk("R4 even parity bits", {56'b0, dp}, {56'b0, exp_par(64'hA1A2_A3A4_A5A6_A7A8, 1'b0)});
        chk("R2 byte order and sync", es + eg, 0);
        chk("R7 second set presented", ins_bytes_o, exp_ins(8'hFF, 1'b0));
    endtask

    task automatic t_odd_bad;
        logic [63:0] dv; logic [7:0] dp; int es, ec, eg;
        par_odd_i = 1'b1;
        run_frame(64'h1122_3344_5566_7788, 8'h08, -1, '0, 1'b0, '0, -1, dv, dp, es, ec, eg);
        chk("R5 last of two strobes wins", dv, 64'hC0C1_C2C3_C4C5_C6C7);
        chk("R4 odd parity bits", {56'b0, dp}, {56'b0, exp_par(64'hC0C1_C2C3_C4C5_C6C7, 1'b1)});
        chk("R8 bad byte keeps old value", ins_bytes_o, exp_ins(8'hFF, 1'b0));
        chk("R8 sticky error raised", {63'b0, par_err_o}, 64'd1);
    endtask

    task automatic t_set_wins;
        logic [63:0] dv; logic [7:0] dp; int es, ec, eg;
        run_frame(64'h99AA_BBCC_DDEE_FF00, 8'h20, -1, '0, 1'b0, '0, 53, dv, dp, es, ec, eg);
        chk("R5 strobe at load edge delayed one frame", dv, 64'hB0B1_B2B3_B4B5_B6B7);
        chk("R8 error set beats clear", {63'b0, par_err_o}, 64'd1);
        chk("R8 bad byte5 held", ins_bytes_o, exp_ins(8'hFF, 1'b0));
    endtask

    task automatic t_stuff;
        ins_en_i = 8'h0F; stuff_ones_i = 1'b1;
        @(negedge clk);
        chk("R9 stuff ones on disabled slots", ins_bytes_o, exp_ins(8'h0F, 1'b1));
        chk("R10 b3 slot forced to stuff", {56'b0, ins_en_o}, 64'h0000_0000_0000_000D);
        stuff_ones_i = 1'b0;
        @(negedge clk);
        chk("R9 stuff zeros on disabled slots", ins_bytes_o, exp_ins(8'h0F, 1'b0));
        err_clr_i = 1'b1;
        @(negedge clk);
        err_clr_i = 1'b0;
        chk("R8 clear alone drops flag", {63'b0, par_err_o}, 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_first_frame();
        t_collision();
        t_odd_bad();
        t_set_wins();
        t_stuff();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule